// File: doc/BRIEF.md
# Multi-Block Byte Transfer Sequencer

This block sits between a 16-bit word FIFO and a byte-wide card data port and moves a transfer made of one or more equal-sized blocks. Software programs a block length in bytes and a block count. Then a data-type command starts the transfer in one direction. Card-to-host transfers pack incoming bytes into FIFO words. Host-to-card transfers unpack FIFO words into outgoing bytes. The low byte of each word always goes first.

Words line up with block boundaries. A block of odd length ends in a word that carries one byte only. The per-block byte counter reloads at every block boundary. The block counter decrements once per block. After the final block the block counter returns to its programmed value, the busy flag drops and an end pulse is raised. The host side reaches the FIFO through plain push and pop strobes. The card side uses a valid/ready handshake in each direction and moves at most one byte per clock.

Top module: `blkxfer_seq`

## Requirements
- R1: A write on `len_wr` sets the block length to `cfg_data` + 1 bytes (the 11-bit field, so 1 to 2048) and loads `len_left` with that length.
- R2: A write on `cnt_wr` sets the block count to `cfg_data` + 1, loads `blk_left` with it and reloads `len_left` from the programmed block length.
- R3: `len_left` and `blk_left` show the live down-counters, never zero. After reset both read 1, `busy` is low and the FIFO is empty.
- R4: In the card-to-host direction (`cmd_rd`=1), two consecutive bytes of a block form one word with the first byte in bits 7:0 and the second in bits 15:8. The last byte of an odd-length block forms a word alone, with bits 15:8 zero.
- R5: In the host-to-card direction (`cmd_rd`=0), each FIFO word sends bits 7:0 first and then bits 15:8. For the last byte of an odd-length block only bits 7:0 are sent, and the word is then removed. An offered byte holds steady until it is accepted.
- R6: When the last byte of a block moves, `len_left` reloads to the block length, `blk_left` decrements and the next block starts on a fresh word.
- R7: When the last byte of the last block moves, `blk_left` returns to the programmed count and `busy` falls. In the following cycle `xfer_end` is high for exactly one cycle.
- R8: In the card-to-host direction, `crd_rx_ready` stays low at a word start while `fifo_level` exceeds `af_level`.
- R9: In the host-to-card direction, `crd_tx_valid` stays low while the FIFO is empty and rises once it holds a word.
- R10: A command with `cmd_data`=1 empties the FIFO, sets `busy` and latches `cmd_rd` as the direction. A command with `cmd_data`=0 clears `busy`.
- R11: A byte moves only on a cycle where valid and ready are both high, and at most one byte moves per clock. A push into a full FIFO (`DEPTH` words) and a pop from an empty FIFO are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| len_wr | input | 1 | Write strobe for the block length |
| cnt_wr | input | 1 | Write strobe for the block count |
| cfg_data | input | 11 | Value for the length or count write (stored plus one) |
| len_left | output | 12 | Bytes remaining in the current block |
| blk_left | output | 12 | Blocks remaining in the transfer |
| cmd_valid | input | 1 | Command strobe |
| cmd_data | input | 1 | Command is a data-type command |
| cmd_rd | input | 1 | Direction of a data command: 1 card-to-host, 0 host-to-card |
| af_level | input | 5 | Almost-full threshold for card-to-host pausing |
| host_push | input | 1 | Host pushes a word into the FIFO |
| host_push_data | input | 16 | Word pushed by the host |
| host_pop | input | 1 | Host pops the head word |
| host_pop_data | output | 16 | FIFO head word |
| fifo_level | output | 6 | Words held in the FIFO |
| crd_rx_valid | input | 1 | Card offers a byte |
| crd_rx_byte | input | 8 | Byte from the card |
| crd_rx_ready | output | 1 | Sequencer accepts the card byte |
| crd_tx_valid | output | 1 | Sequencer offers a byte to the card |
| crd_tx_byte | output | 8 | Byte to the card |
| crd_tx_ready | input | 1 | Card accepts the byte |
| busy | output | 1 | Transfer in progress |
| xfer_end | output | 1 | One-cycle pulse after the last byte of the transfer |

## Verification
The embedded properties assume that the host pushes no words during a card-to-host transfer and pops none during a host-to-card transfer. They also assume that no length or count write and no command arrive on the same edge as a transfer's final byte, so the FIFO and counters change only through the sequencer when those properties are judged. The stimulus issues every register write and command while the port handshakes are idle or the transfer has finished. Host pops are used only for card-to-host data and host pushes only for host-to-card data or while idle, so each property is exercised only under the conditions it takes for granted.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
  localparam int FIELD_W = 11;
  localparam int CNT_W   = FIELD_W + 1;

  typedef enum logic {DIR_TO_CARD = 1'b0, DIR_FROM_CARD = 1'b1} dir_e;

  // programmed field value -> count (field + 1)
  function automatic logic [CNT_W-1:0] field_to_count(input logic [FIELD_W-1:0] v);
    return CNT_W'(v) + CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] count_dec(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction
endpackage

// File: rtl/bxs_fifo.sv
module bxs_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign push_ok = push && (level != LW'(DEPTH));
  assign pop_ok  = pop && (level != '0);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/bxs_count.sv
module bxs_count
  import bxs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               len_wr,
  input  logic               cnt_wr,
  input  logic [FIELD_W-1:0] cfg_data,
  input  logic               step,
  output logic [CNT_W-1:0]   len_left,
  output logic [CNT_W-1:0]   blk_left,
  output logic               blk_tail,
  output logic               last_step
);
  logic [CNT_W-1:0] blk_len, blk_num;
  logic             blk_end;

  assign blk_tail  = (len_left == CNT_W'(1));
  assign blk_end   = step && blk_tail;
  assign last_step = blk_end && (blk_left == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_len  <= CNT_W'(1);
      blk_num  <= CNT_W'(1);
      len_left <= CNT_W'(1);
      blk_left <= CNT_W'(1);
    end else if (len_wr) begin
      blk_len  <= field_to_count(cfg_data);
      len_left <= field_to_count(cfg_data);
    end else if (cnt_wr) begin
      blk_num  <= field_to_count(cfg_data);
      blk_left <= field_to_count(cfg_data);
      len_left <= blk_len;
    end else if (blk_end) begin
      len_left <= blk_len;
      blk_left <= last_step ? blk_num : count_dec(blk_left);
    end else if (step) begin
      len_left <= count_dec(len_left);
    end
  end

  a_r3_counts_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (len_left != '0) && (blk_left != '0));

  a_r6_block_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (step && blk_tail && !len_wr && !cnt_wr) |=> (len_left == blk_len));
endmodule

// File: rtl/bxs_pack.sv
module bxs_pack
  import bxs_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AFW  = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           busy,
  input  dir_e           dir,
  input  logic [AFW-1:0] af_level,
  input  logic [LW-1:0]  fifo_level,
  input  logic [15:0]    head,
  input  logic           blk_tail,
  input  logic           rx_valid,
  input  logic [7:0]     rx_byte,
  output logic           rx_ready,
  output logic           tx_valid,
  output logic [7:0]     tx_byte,
  input  logic           tx_ready,
  output logic           push,
  output logic [15:0]    push_word,
  output logic           pop,
  output logic           step
);
  logic       half;      // low byte of the current word already moved
  logic [7:0] lo_byte;
  logic       rx_fire, tx_fire, word_done, room;

  assign room      = (fifo_level <= LW'(af_level));
  assign rx_ready  = busy && (dir == DIR_FROM_CARD) && (half || room);
  assign tx_valid  = busy && (dir == DIR_TO_CARD) && (fifo_level != '0);
  assign tx_byte   = half ? head[15:8] : head[7:0];
  assign rx_fire   = rx_valid && rx_ready;
  assign tx_fire   = tx_valid && tx_ready;
  assign step      = rx_fire || tx_fire;
  assign word_done = half || blk_tail;
  assign push      = rx_fire && word_done;
  assign pop       = tx_fire && word_done;
  assign push_word = half ? {rx_byte, lo_byte} : {8'h00, rx_byte};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half    <= 1'b0;
      lo_byte <= '0;
    end else if (start) begin
      half <= 1'b0;
    end else if (step) begin
      half <= !word_done;
      if (rx_fire && !half) lo_byte <= rx_byte;
    end
  end

  a_r8_rx_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (!half && (fifo_level > LW'(af_level))) |-> !rx_ready);
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import bxs_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AFW  = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               len_wr,
  input  logic               cnt_wr,
  input  logic [FIELD_W-1:0] cfg_data,
  output logic [CNT_W-1:0]   len_left,
  output logic [CNT_W-1:0]   blk_left,
  input  logic               cmd_valid,
  input  logic               cmd_data,
  input  logic               cmd_rd,
  input  logic [AFW-1:0]     af_level,
  input  logic               host_push,
  input  logic [15:0]        host_push_data,
  input  logic               host_pop,
  output logic [15:0]        host_pop_data,
  output logic [LW-1:0]      fifo_level,
  input  logic               crd_rx_valid,
  input  logic [7:0]         crd_rx_byte,
  output logic               crd_rx_ready,
  output logic               crd_tx_valid,
  output logic [7:0]         crd_tx_byte,
  input  logic               crd_tx_ready,
  output logic               busy,
  output logic               xfer_end
);
  dir_e        dir_q;
  logic        start, step, blk_tail, last_step;
  logic        pk_push, pk_pop;
  logic [15:0] pk_word;

  assign start = cmd_valid && cmd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      dir_q    <= DIR_TO_CARD;
      xfer_end <= 1'b0;
    end else begin
      xfer_end <= last_step;
      if (cmd_valid) begin
        busy <= cmd_data;
        if (cmd_data) dir_q <= cmd_rd ? DIR_FROM_CARD : DIR_TO_CARD;
      end else if (last_step) begin
        busy <= 1'b0;
      end
    end
  end

  bxs_count u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .len_wr   (len_wr),
    .cnt_wr   (cnt_wr),
    .cfg_data (cfg_data),
    .step     (step),
    .len_left (len_left),
    .blk_left (blk_left),
    .blk_tail (blk_tail),
    .last_step(last_step)
  );

  bxs_pack #(.DEPTH(DEPTH)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .dir       (dir_q),
    .af_level  (af_level),
    .fifo_level(fifo_level),
    .head      (host_pop_data),
    .blk_tail  (blk_tail),
    .rx_valid  (crd_rx_valid),
    .rx_byte   (crd_rx_byte),
    .rx_ready  (crd_rx_ready),
    .tx_valid  (crd_tx_valid),
    .tx_byte   (crd_tx_byte),
    .tx_ready  (crd_tx_ready),
    .push      (pk_push),
    .push_word (pk_word),
    .pop       (pk_pop),
    .step      (step)
  );

  bxs_fifo #(.DEPTH(DEPTH), .W(16)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (start),
    .push     (pk_push || host_push),
    .push_data(pk_push ? pk_word : host_push_data),
    .pop      (pk_pop || host_pop),
    .head     (host_pop_data),
    .level    (fifo_level)
  );

  a_r11_push_room: assert property (@(posedge clk) disable iff (!rst_n)
    pk_push |-> (fifo_level < LW'(DEPTH)));

  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (crd_tx_valid && !crd_tx_ready && !host_pop && !cmd_valid)
      |=> (crd_tx_valid && $stable(crd_tx_byte)));

  a_r7_end_single: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> !xfer_end);

  a_r7_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && !$past(cmd_valid)) |-> !busy);
endmodule

// File: tb/sim_blkxfer_seq.sv
module sim_blkxfer_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        len_wr = 0, cnt_wr = 0;
  logic [10:0] cfg_data = '0;
  logic [11:0] len_left, blk_left;
  logic        cmd_valid = 0, cmd_data = 0, cmd_rd = 0;
  logic [4:0]  af_level = 5'd31;
  logic        host_push = 0, host_pop = 0;
  logic [15:0] host_push_data = '0, host_pop_data;
  logic [5:0]  fifo_level;
  logic        crd_rx_valid = 0, crd_rx_ready;
  logic [7:0]  crd_rx_byte = 8'h10;
  logic        crd_tx_valid, crd_tx_ready = 0;
  logic [7:0]  crd_tx_byte;
  logic        busy, xfer_end;

  blkxfer_seq u0 (.*);

  int n_chk = 0, n_err = 0;
  int end_cnt = 0, tx_cnt = 0;
  int rx_pos = 0, mdl_len = 1;
  logic [7:0]  rx_lo = '0;
  logic        rx_take = 0, prev_end = 0;
  logic [15:0] exp_rx[$];
  logic [7:0]  exp_tx[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard, samples mid low phase
  always begin
    @(negedge clk);
    if (rx_take) begin crd_rx_byte = crd_rx_byte + 8'd1; rx_take = 0; end
    #5;
    if (rst_n) begin
      if (crd_rx_valid && crd_rx_ready) begin
        if (rx_pos % 2 == 0) begin
          if (rx_pos == mdl_len - 1) exp_rx.push_back({8'h00, crd_rx_byte});
          else rx_lo = crd_rx_byte;
        end else exp_rx.push_back({crd_rx_byte, rx_lo});
        rx_pos = (rx_pos + 1 == mdl_len) ? 0 : rx_pos + 1;
        rx_take = 1;
      end
      if (crd_tx_valid && crd_tx_ready) begin
        tx_cnt++;
        if (exp_tx.size() == 0) check("R5 unexpected tx byte", {24'h0, crd_tx_byte}, 32'hFFFF);
        else check("R5 tx byte order", {24'h0, crd_tx_byte}, {24'h0, exp_tx.pop_front()});
      end
      if (host_pop && fifo_level != 0) begin
        if (exp_rx.size() == 0) check("R4 unexpected word", {16'h0, host_pop_data}, 32'hFFFF);
        else check("R4 packed word", {16'h0, host_pop_data}, {16'h0, exp_rx.pop_front()});
      end
      if (xfer_end) begin
        end_cnt++;
        if (prev_end) check("R7 end pulse width", 1, 0);
      end
      prev_end = xfer_end;
    end
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic wr_len(input logic [10:0] v);
    @(negedge clk); len_wr = 1; cfg_data = v; @(negedge clk); len_wr = 0;
  endtask
  task automatic wr_cnt(input logic [10:0] v);
    @(negedge clk); cnt_wr = 1; cfg_data = v; @(negedge clk); cnt_wr = 0;
  endtask
  task automatic command(input logic dat, input logic rd);
    @(negedge clk); cmd_valid = 1; cmd_data = dat; cmd_rd = rd;
    @(negedge clk); cmd_valid = 0;
  endtask
  task automatic push_word(input logic [15:0] w);
    @(negedge clk); host_push = 1; host_push_data = w;
    @(negedge clk); host_push = 0;
  endtask
  task automatic pop_one();
    @(negedge clk); host_pop = 1; @(negedge clk); host_pop = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    tick(3); rst_n = 1; tick(1);
    // R3 reset state
    check("R3 len_left reset", len_left, 1);
    check("R3 blk_left reset", blk_left, 1);
    check("R3 busy reset", busy, 0);
    check("R3 fifo empty", fifo_level, 0);

    // R1 / R2 register semantics
    wr_len(11'h405);
    check("R1 len_left loaded", len_left, 12'h406);
    wr_len(11'h005);
    check("R1 len_left small", len_left, 6);
    wr_cnt(11'h003);
    check("R2 blk_left loaded", blk_left, 4);
    check("R2 len reloaded", len_left, 6);
    wr_cnt(11'h7FF);
    check("R2 max count", blk_left, 12'd2048);

    // R11 full / empty, R10 commands
    for (int i = 0; i < 33; i++) push_word(16'(i));
    check("R11 push when full ignored", fifo_level, 32);
    command(1, 1);
    check("R10 data cmd flushes", fifo_level, 0);
    check("R10 data cmd sets busy", busy, 1);
    check("R8 ready with room", crd_rx_ready, 1);
    command(0, 0);
    check("R10 other cmd clears busy", busy, 0);
    check("R10 idle no ready", crd_rx_ready, 0);
    @(negedge clk); host_pop = 1; @(negedge clk); host_pop = 0;
    check("R11 pop when empty ignored", fifo_level, 0);

    // R4 / R7 card-to-host, odd block length 3, two blocks
    wr_len(11'd2); wr_cnt(11'd1);
    mdl_len = 3; rx_pos = 0;
    command(1, 1);
    crd_rx_valid = 1;
    wait (end_cnt == 1);
    @(negedge clk); crd_rx_valid = 0;
    check("R7 busy cleared", busy, 0);
    check("R7 blk_left restored", blk_left, 2);
    check("R6 len_left at end", len_left, 3);
    check("R4 word count", fifo_level, 4);
    while (fifo_level != 0) pop_one();
    check("R4 all words seen", exp_rx.size(), 0);

    // R8 pause at almost-full, length 8, one block
    af_level = 5'd1;
    wr_len(11'd7); wr_cnt(11'd0);
    mdl_len = 8; rx_pos = 0;
    command(1, 1);
    crd_rx_valid = 1;
    tick(12);
    check("R8 stalled level", fifo_level, 2);
    check("R8 ready low over level", crd_rx_ready, 0);
    check("R8 bytes left", len_left, 4);
    while (busy) begin pop_one(); tick(3); end
    @(negedge clk); crd_rx_valid = 0;
    check("R7 second end", end_cnt, 2);
    while (fifo_level != 0) pop_one();
    check("R4 stall words seen", exp_rx.size(), 0);
    af_level = 5'd31;

    // R5 / R6 / R9 host-to-card, length 3, two blocks
    wr_len(11'd2); wr_cnt(11'd1);
    crd_tx_ready = 0;
    command(1, 0);
    tick(2);
    check("R9 no valid when empty", crd_tx_valid, 0);
    exp_tx.push_back(8'hA0); exp_tx.push_back(8'hA1); exp_tx.push_back(8'hA2);
    exp_tx.push_back(8'hB0); exp_tx.push_back(8'hB1); exp_tx.push_back(8'hB2);
    push_word(16'hA1A0); push_word(16'hEEA2);
    push_word(16'hB1B0); push_word(16'hEEB2);
    check("R9 valid with data", crd_tx_valid, 1);
    check("R5 first byte low", crd_tx_byte, 8'hA0);
    tick(2);
    check("R5 held while not ready", crd_tx_byte, 8'hA0);
    crd_tx_ready = 1;
    wait (tx_cnt == 3);
    @(negedge clk); crd_tx_ready = 0;
    check("R6 len reload", len_left, 3);
    check("R6 blk decrement", blk_left, 1);
    check("R5 odd word dropped", fifo_level, 2);
    check("R6 fresh word", crd_tx_byte, 8'hB0);
    crd_tx_ready = 1;
    wait (end_cnt == 3);
    @(negedge clk); crd_tx_ready = 0;
    check("R7 tx end busy", busy, 0);
    check("R7 tx blk restored", blk_left, 2);
    check("R5 fifo drained", fifo_level, 0);
    check("R11 one byte per clock total", tx_cnt, 6);
    check("R5 all bytes seen", exp_tx.size(), 0);
    summary();
  end
endmodule